// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a non-pipelined 32-bit processor that has one shared memory and one shared ALU. Every instruction is split into short steps of one cycle each: fetch, decode, execute or address computation, memory access, and write-back. The sequencer holds the current step in a 4-bit state register. In every cycle it drives the strobes and mux selects that tell the datapath what to do in that step.

The sequencer reads the 6-bit opcode field from the instruction register. That field stays stable from the end of fetch until the next fetch. The sequencer handles five instruction classes: word load, word store, register-to-register arithmetic, branch-if-equal and jump. Each class takes between 3 and 5 cycles. During decode, the ALU computes the branch target before the instruction class is known. Any opcode outside these classes sends the machine straight back to fetch. Every output is decoded from the state alone, so the outputs are a Moore function of the state.

Top module: `multicycle_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the machine in state 0 (fetch) at the next rising edge.
- R2: State 0 drives memRead=1, irWrite=1, pcWrite=1, iorD=0, aluSrcA=0, aluSrcB=01, aluOp=00 and pcSource=00, with all other strobes 0. State 0 is always followed by state 1.
- R3: State 1 (decode) drives aluSrcA=0, aluSrcB=11 and aluOp=00, with every other strobe 0.
- R4: Opcode 35 (load) follows the path 0,1,2,3,4,0, which is 5 cycles. State 2 drives aluSrcA=1, aluSrcB=10 and aluOp=00. State 3 drives memRead=1 and iorD=1. State 4 drives regWrite=1, regDst=0 and memToReg=1.
- R5: Opcode 43 (store) follows the path 0,1,2,5,0, which is 4 cycles. State 5 drives memWrite=1 and iorD=1.
- R6: Opcode 0 (register arithmetic) follows the path 0,1,6,7,0, which is 4 cycles. State 6 drives aluSrcA=1, aluSrcB=00 and aluOp=10. State 7 drives regWrite=1, regDst=1 and memToReg=0.
- R7: Opcode 4 (branch-if-equal) follows the path 0,1,8,0, which is 3 cycles. State 8 drives aluSrcA=1, aluSrcB=00, aluOp=01, pcWriteCond=1 and pcSource=01.
- R8: Opcode 2 (jump) follows the path 0,1,9,0, which is 3 cycles. State 9 drives pcWrite=1 and pcSource=10.
- R9: Any other opcode returns from state 1 to state 0, so the instruction takes 2 cycles.
- R10: In every state, any strobe not named for that state is 0. memRead and memWrite are never both 1, and pcWrite and pcWriteCond are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| ctrlState | output | 4 | Current step number (0 to 9) |
| pcWrite | output | 1 | Unconditional program counter write |
| pcWriteCond | output | 1 | Program counter write when the ALU result is zero |
| iorD | output | 1 | Memory address select: 0 = PC, 1 = ALU output register |
| memRead | output | 1 | Memory read strobe |
| memWrite | output | 1 | Memory write strobe |
| irWrite | output | 1 | Instruction register load |
| memToReg | output | 1 | Register write data select: 1 = memory data register |
| pcSource | output | 2 | Next-PC select: 00 ALU, 01 ALU output register, 10 jump target |
| aluOp | output | 2 | ALU operation class: 00 add, 01 subtract, 10 by function field |
| aluSrcA | output | 1 | ALU A select: 0 = PC, 1 = register A |
| aluSrcB | output | 2 | ALU B select: 00 reg B, 01 constant 4, 10 offset, 11 offset times 4 |
| regWrite | output | 1 | Register file write |
| regDst | output | 1 | Destination register select: 1 = rd field, 0 = rt field |

## Verification
The state register is the only register in the block. A change of opcode therefore affects ctrlState one rising edge after the machine sits in state 1, or in state 2 for the load/store split. Every strobe changes in the same cycle as the state, because the strobes are decoded from it. The bench drives inputs and samples all outputs on the falling edge. At each sample it compares the state and the full strobe word against the values expected for the step reached after the previous rising edge. It counts the falling edges from the sample where state 0 is seen until state 0 is seen again, which gives the cycles taken by each instruction class.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int OP_W    = 6;
  localparam int STATE_W = 4;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'd0;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'd2;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'd4;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'd35;
  localparam logic [OP_W-1:0] OP_STORE = 6'd43;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH    = 4'd0,
    ST_DECODE   = 4'd1,
    ST_ADDR     = 4'd2,
    ST_MEMRD    = 4'd3,
    ST_LOADWB   = 4'd4,
    ST_MEMWR    = 4'd5,
    ST_EXEC     = 4'd6,
    ST_ALUWB    = 4'd7,
    ST_BRANCH   = 4'd8,
    ST_JUMP     = 4'd9
  } stepState_t;

  typedef struct packed {
    logic       pcWrite;
    logic       pcWriteCond;
    logic       iorD;
    logic       memRead;
    logic       memWrite;
    logic       irWrite;
    logic       memToReg;
    logic [1:0] pcSource;
    logic [1:0] aluOp;
    logic       aluSrcA;
    logic [1:0] aluSrcB;
    logic       regWrite;
    logic       regDst;
  } ctrlStrobes_t;

endpackage

// File: rtl/mc_ctrl_sequencer.sv
module mc_ctrl_sequencer
  import mc_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output stepState_t      curState
);

  stepState_t nextState;

  always_comb begin
    nextState = ST_FETCH;
    unique case (curState)
      ST_FETCH:  nextState = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OP_LOAD || opcode == OP_STORE) nextState = ST_ADDR;
        else if (opcode == OP_RTYPE)                 nextState = ST_EXEC;
        else if (opcode == OP_BEQ)                   nextState = ST_BRANCH;
        else if (opcode == OP_JUMP)                  nextState = ST_JUMP;
        else                                         nextState = ST_FETCH;
      end
      ST_ADDR:   nextState = (opcode == OP_LOAD) ? ST_MEMRD : ST_MEMWR;
      ST_MEMRD:  nextState = ST_LOADWB;
      ST_EXEC:   nextState = ST_ALUWB;
      default:   nextState = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_FETCH;
    else     curState <= nextState;
  end

endmodule

// File: rtl/mc_ctrl_decoder.sv
module mc_ctrl_decoder
  import mc_ctrl_pkg::*;
(
  input  stepState_t   curState,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    unique case (curState)
      ST_FETCH: begin
        strobes.memRead  = 1'b1;
        strobes.irWrite  = 1'b1;
        strobes.pcWrite  = 1'b1;
        strobes.aluSrcB  = 2'b01;
      end
      ST_DECODE: begin
        strobes.aluSrcB  = 2'b11;
      end
      ST_ADDR: begin
        strobes.aluSrcA  = 1'b1;
        strobes.aluSrcB  = 2'b10;
      end
      ST_MEMRD: begin
        strobes.memRead  = 1'b1;
        strobes.iorD     = 1'b1;
      end
      ST_LOADWB: begin
        strobes.regWrite = 1'b1;
        strobes.memToReg = 1'b1;
      end
      ST_MEMWR: begin
        strobes.memWrite = 1'b1;
        strobes.iorD     = 1'b1;
      end
      ST_EXEC: begin
        strobes.aluSrcA  = 1'b1;
        strobes.aluOp    = 2'b10;
      end
      ST_ALUWB: begin
        strobes.regWrite = 1'b1;
        strobes.regDst   = 1'b1;
      end
      ST_BRANCH: begin
        strobes.aluSrcA     = 1'b1;
        strobes.aluOp       = 2'b01;
        strobes.pcWriteCond = 1'b1;
        strobes.pcSource    = 2'b01;
      end
      ST_JUMP: begin
        strobes.pcWrite  = 1'b1;
        strobes.pcSource = 2'b10;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/multicycle_ctrl.sv
module multicycle_ctrl
  import mc_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [OP_W-1:0]    opcode,
  output logic [STATE_W-1:0] ctrlState,
  output logic               pcWrite,
  output logic               pcWriteCond,
  output logic               iorD,
  output logic               memRead,
  output logic               memWrite,
  output logic               irWrite,
  output logic               memToReg,
  output logic [1:0]         pcSource,
  output logic [1:0]         aluOp,
  output logic               aluSrcA,
  output logic [1:0]         aluSrcB,
  output logic               regWrite,
  output logic               regDst
);

  stepState_t   curState;
  ctrlStrobes_t strobes;

  mc_ctrl_sequencer u_seq (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .curState (curState)
  );

  mc_ctrl_decoder u_dec (
    .curState (curState),
    .strobes  (strobes)
  );

  assign ctrlState   = curState;
  assign pcWrite     = strobes.pcWrite;
  assign pcWriteCond = strobes.pcWriteCond;
  assign iorD        = strobes.iorD;
  assign memRead     = strobes.memRead;
  assign memWrite    = strobes.memWrite;
  assign irWrite     = strobes.irWrite;
  assign memToReg    = strobes.memToReg;
  assign pcSource    = strobes.pcSource;
  assign aluOp       = strobes.aluOp;
  assign aluSrcA     = strobes.aluSrcA;
  assign aluSrcB     = strobes.aluSrcB;
  assign regWrite    = strobes.regWrite;
  assign regDst      = strobes.regDst;

endmodule

// File: rtl/multicycle_ctrl_checker.sv
module multicycle_ctrl_checker (
  input logic       clk,
  input logic       rst,
  input logic [5:0] opcode,
  input logic [3:0] ctrlState,
  input logic       pcWrite,
  input logic       pcWriteCond,
  input logic       memRead,
  input logic       memWrite,
  input logic       irWrite
);

  logic knownOp;
  assign knownOp = (opcode == 6'd0) || (opcode == 6'd2) || (opcode == 6'd4) ||
                   (opcode == 6'd35) || (opcode == 6'd43);

  a_r1_reset_to_fetch: assert property (@(posedge clk)
    rst |=> ctrlState == 4'd0);

  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
    ctrlState == 4'd0 |=> ctrlState == 4'd1 && $past(irWrite));

  a_r4_load_steps: assert property (@(posedge clk) disable iff (rst)
    ctrlState == 4'd3 |=> ctrlState == 4'd4);

  a_r5_store_return: assert property (@(posedge clk) disable iff (rst)
    ctrlState == 4'd5 |=> ctrlState == 4'd0);

  a_r7_beq_entry: assert property (@(posedge clk) disable iff (rst)
    ctrlState == 4'd1 && opcode == 6'd4 |=> ctrlState == 4'd8);

  a_r8_jump_entry: assert property (@(posedge clk) disable iff (rst)
    ctrlState == 4'd1 && opcode == 6'd2 |=> ctrlState == 4'd9);

  a_r9_unknown_op: assert property (@(posedge clk) disable iff (rst)
    ctrlState == 4'd1 && !knownOp |=> ctrlState == 4'd0);

  a_r10_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(memRead && memWrite));

  a_r10_pc_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pcWrite && pcWriteCond));

endmodule

bind multicycle_ctrl multicycle_ctrl_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .opcode      (opcode),
  .ctrlState   (ctrlState),
  .pcWrite     (pcWrite),
  .pcWriteCond (pcWriteCond),
  .memRead     (memRead),
  .memWrite    (memWrite),
  .irWrite     (irWrite)
);

// File: tb/multicycle_ctrl_test.sv
module multicycle_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic [3:0] ctrlState;
  logic pcWrite, pcWriteCond, iorD, memRead, memWrite, irWrite, memToReg;
  logic [1:0] pcSource, aluOp, aluSrcB;
  logic aluSrcA, regWrite, regDst;

  int testCount = 0;
  int failCount = 0;

  always #10 clk = ~clk;

  multicycle_ctrl uut (
    .clk(clk), .rst(rst), .opcode(opcode), .ctrlState(ctrlState),
    .pcWrite(pcWrite), .pcWriteCond(pcWriteCond), .iorD(iorD),
    .memRead(memRead), .memWrite(memWrite), .irWrite(irWrite),
    .memToReg(memToReg), .pcSource(pcSource), .aluOp(aluOp),
    .aluSrcA(aluSrcA), .aluSrcB(aluSrcB), .regWrite(regWrite),
    .regDst(regDst)
  );

  // strobe word: pcWrite pcWriteCond iorD memRead memWrite irWrite memToReg
  //              pcSource[2] aluOp[2] aluSrcA aluSrcB[2] regWrite regDst
  logic [15:0] gotWord;
  assign gotWord = {pcWrite, pcWriteCond, iorD, memRead, memWrite, irWrite,
                    memToReg, pcSource, aluOp, aluSrcA, aluSrcB, regWrite, regDst};

  function automatic logic [15:0] expWord(input logic [3:0] st);
    logic [15:0] w;
    w = '0;
    case (st)
      4'd0: begin w[15] = 1; w[12] = 1; w[10] = 1; w[3:2] = 2'b01; end
      4'd1: w[3:2] = 2'b11;
      4'd2: begin w[4] = 1; w[3:2] = 2'b10; end
      4'd3: begin w[12] = 1; w[13] = 1; end
      4'd4: begin w[1] = 1; w[9] = 1; end
      4'd5: begin w[11] = 1; w[13] = 1; end
      4'd6: begin w[4] = 1; w[6:5] = 2'b10; end
      4'd7: begin w[1] = 1; w[0] = 1; end
      4'd8: begin w[4] = 1; w[6:5] = 2'b01; w[14] = 1; w[8:7] = 2'b01; end
      4'd9: begin w[15] = 1; w[8:7] = 2'b10; end
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic [3:0] expNext(input logic [3:0] st, input logic [5:0] op);
    case (st)
      4'd0: return 4'd1;
      4'd1: case (op)
              6'd35, 6'd43: return 4'd2;
              6'd0:         return 4'd6;
              6'd4:         return 4'd8;
              6'd2:         return 4'd9;
              default:      return 4'd0;
            endcase
      4'd2: return (op == 6'd35) ? 4'd3 : 4'd5;
      4'd3: return 4'd4;
      4'd6: return 4'd7;
      default: return 4'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  localparam int NVEC = 8;
  localparam logic [5:0] VEC_OP  [NVEC] = '{6'd35, 6'd43, 6'd0, 6'd4, 6'd2, 6'd63, 6'd5, 6'd0};
  localparam int         VEC_LEN [NVEC] = '{5, 4, 4, 3, 3, 2, 2, 4};
  localparam string      VEC_REQ [NVEC] = '{"R4", "R5", "R6", "R7", "R8", "R9", "R9", "R6"};

  task automatic runInstr(input logic [5:0] op, input int expLen, input string req);
    logic [3:0] expSt;
    int cycles;
    expSt = 4'd0;
    cycles = 0;
    opcode = op;
    do begin
      check(ctrlState == expSt, req, ctrlState, expSt);
      check(gotWord == expWord(expSt), (expSt == 0) ? "R2" : "R10", gotWord, expWord(expSt));
      check(!(memRead && memWrite) && !(pcWrite && pcWriteCond), "R10", gotWord, 0);
      expSt = expNext(expSt, op);
      cycles++;
      @(negedge clk);
    end while (expSt != 4'd0 && cycles < 10);
    check(ctrlState == 4'd0 && cycles == expLen, req, cycles, expLen);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(ctrlState == 4'd0, "R1", ctrlState, 0);
    check(gotWord == expWord(4'd0), "R2", gotWord, expWord(4'd0));

    for (int i = 0; i < NVEC; i++) runInstr(VEC_OP[i], VEC_LEN[i], VEC_REQ[i]);

    // R3 decode strobes with unknown opcode
    opcode = 6'd17;
    @(negedge clk);
    check(ctrlState == 4'd1 && gotWord == expWord(4'd1), "R3", gotWord, expWord(4'd1));
    @(negedge clk);
    check(ctrlState == 4'd0, "R9", ctrlState, 0);

    // R1 reset in the middle of a load (state 3)
    opcode = 6'd35;
    repeat (3) @(negedge clk);
    check(ctrlState == 4'd3, "R4", ctrlState, 3);
    rst = 1'b1;
    @(negedge clk);
    check(ctrlState == 4'd0, "R1", ctrlState, 0);
    @(negedge clk);
    check(ctrlState == 4'd0, "R1", ctrlState, 0);
    rst = 1'b0;
    @(negedge clk);
    check(ctrlState == 4'd1, "R2", ctrlState, 1);
    @(negedge clk);
    check(ctrlState == 4'd2, "R4", ctrlState, 2);
    repeat (3) @(negedge clk);
    check(ctrlState == 4'd0, "R4", ctrlState, 0);

    // back-to-back jump and branch
    runInstr(6'd2, 3, "R8");
    runInstr(6'd4, 3, "R7");

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule